// File: doc/BRIEF.md
# Endpoint DMA Descriptor Locator

This block sits between the endpoint logic of a USB device controller and system memory. Its job is to find the first DMA descriptor that belongs to a physical endpoint. Software writes a base register that points to a table in RAM. The table holds one descriptor pointer per physical endpoint. When the endpoint logic presents a request for an endpoint index, the block does the following in order:

- It checks whether that endpoint is both realized in hardware and enabled for DMA.
- If so, it forms the address of the table word and reads the word through a single-outstanding read port.
- It reports either a descriptor start address or a "no descriptor" result.

The result stays on the outputs while the packet transfers for that descriptor run. The requester finishes with the descriptor in one of two ways:

- It pulses a completion input, which returns the block to idle.
- It pulses an advance input. The block then reads the next-descriptor word at offset 0 of the current descriptor. It presents the following descriptor, or end-of-chain when that word is zero.

Top module: `ep_desc_locator`

## Requirements
- R1: After a synchronous active-low reset, the base register is zero, `req_ready` is 1, and `mem_req_valid` and `res_valid` are 0.
- R2: A base write keeps bits [31:7] and forces bits [6:0] to zero. The table read for endpoint n goes to address base + 4·n, so the index appears at address bits [6:2].
- R3: A request is taken only while `req_ready` is 1 (idle). A request presented while busy is ignored and does not change the read address or the result.
- R4: For an endpoint whose bit in `ep_dma_en` is 0, or which the REALIZED parameter marks absent, the block issues no memory read. It reports `res_valid`=1 with `res_found`=0 and `res_desc_addr`=0.
- R5: A table word of 0x0 yields `res_found`=0 and `res_desc_addr`=0, and no further read is issued.
- R6: A non-zero table word yields `res_found`=1, with `res_desc_addr` equal to that word.
- R7: At most one read is outstanding. While `mem_req_valid` is high and `mem_req_ready` is low, the request and its address hold. No new request is raised until the response has arrived.
- R8: `advance` with `res_found`=1 reads the word at `res_desc_addr` + 0. A non-zero word becomes the new descriptor address. A zero word gives end-of-chain, with `res_found`=0.
- R9: While `res_valid` is high and neither `advance` nor `xfer_done` is asserted, the result holds. `xfer_done` takes priority over `advance` and returns the block to idle on the next cycle.
- R10: `advance` while `res_found`=0 is ignored: no read is issued and the result stays.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_wr_en | input | 1 | Write strobe for the table base register |
| base_wr_data | input | 32 | Base value; bits [6:0] are discarded |
| ep_dma_en | input | 32 | Per-endpoint DMA enable, bit n for endpoint n |
| req_valid | input | 1 | Endpoint service request |
| req_ep | input | 5 | Physical endpoint index of the request |
| req_ready | output | 1 | High when idle and able to take a request |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Byte address of the word to read |
| mem_rsp_valid | input | 1 | Read data is valid |
| mem_rsp_data | input | 32 | Read data word |
| res_valid | output | 1 | Result is present |
| res_found | output | 1 | A descriptor exists at `res_desc_addr` |
| res_desc_addr | output | 32 | Descriptor start address, 0 when none |
| advance | input | 1 | Follow the next-descriptor pointer |
| xfer_done | input | 1 | Packet transfers for this descriptor are complete |

## Verification
The bench builds the block with 32 endpoints and sets REALIZED so that endpoint 2 is missing. This exposes the "not realized" path even when software has enabled that endpoint. The memory model accepts a request only on every other cycle and answers two cycles later. Every read therefore sees back-pressure, which exercises the address-hold and single-outstanding rules. Two base values with their low bits set, one near the top of the address space, bring the alignment masking and the index placement within reach. A three-link chain covers both a next-pointer hit and end-of-chain.

// File: rtl/epdl_pkg.sv
package epdl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_TABLE,
        ST_CHECK,
        ST_DONE,
        ST_READ_NEXT
    } epdl_state_e;

endpackage

// File: rtl/epdl_base_reg.sv
module epdl_base_reg #(
    parameter int AW      = 32,
    parameter int ALIGN_W = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_data,
    output logic [AW-1:0] base_o
);
    localparam logic [AW-1:0] KEEP_MASK = ~((AW'(1) << ALIGN_W) - AW'(1));

    logic [AW-1:0] base_d, base_q;

    always_comb begin
        base_d = base_q;
        if (wr_en) begin
            base_d = wr_data & KEEP_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else begin
            base_q <= base_d;
        end
    end

    assign base_o = base_q;
endmodule

// File: rtl/epdl_entry_sel.sv
module epdl_entry_sel #(
    parameter int                AW       = 32,
    parameter int                NUM_EP   = 32,
    parameter int                IDX_W    = 5,
    parameter logic [NUM_EP-1:0] REALIZED = '1
) (
    input  logic [AW-1:0]     base_i,
    input  logic [IDX_W-1:0]  ep_i,
    input  logic [NUM_EP-1:0] en_mask_i,
    output logic [AW-1:0]     entry_addr_o,
    output logic              ep_ok_o
);
    localparam int PAD_W = AW - IDX_W - 2;

    logic [NUM_EP-1:0] usable;

    for (genvar g = 0; g < NUM_EP; g++) begin : g_usable
        if (REALIZED[g]) begin : g_real
            assign usable[g] = en_mask_i[g];
        end else begin : g_absent
            assign usable[g] = 1'b0;
        end
    end

    assign ep_ok_o      = usable[ep_i];
    assign entry_addr_o = base_i + {{PAD_W{1'b0}}, ep_i, 2'b00};
endmodule

// File: rtl/epdl_ctrl.sv
module epdl_ctrl
    import epdl_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          ep_ok,
    input  logic [AW-1:0] entry_addr,
    output logic          req_ready,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic [AW-1:0] mem_req_addr,
    input  logic          mem_rsp_valid,
    input  logic [DW-1:0] mem_rsp_data,
    output logic          res_valid,
    output logic          res_found,
    output logic [AW-1:0] res_desc_addr,
    input  logic          advance,
    input  logic          xfer_done
);
    typedef struct packed {
        epdl_state_e   state;
        logic          sent;
        logic [AW-1:0] addr;
        logic [AW-1:0] ptr;
        logic          found;
    } ctrl_t;

    ctrl_t d, q;
    logic  reading;

    assign reading = (q.state == ST_READ_TABLE) || (q.state == ST_READ_NEXT);

    always_comb begin
        d = q;
        unique case (q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    if (ep_ok) begin
                        d.state = ST_READ_TABLE;
                        d.addr  = entry_addr;
                        d.sent  = 1'b0;
                    end else begin
                        d.state = ST_DONE;
                        d.ptr   = '0;
                        d.found = 1'b0;
                    end
                end
            end
            ST_READ_TABLE, ST_READ_NEXT: begin
                if (!q.sent && mem_req_ready) begin
                    d.sent = 1'b1;
                end
                if (q.sent && mem_rsp_valid) begin
                    d.ptr   = AW'(mem_rsp_data);
                    d.sent  = 1'b0;
                    d.state = ST_CHECK;
                end
            end
            ST_CHECK: begin
                d.found = (q.ptr != '0);
                d.state = ST_DONE;
            end
            ST_DONE: begin
                if (xfer_done) begin
                    d.state = ST_IDLE;
                end else if (advance && q.found) begin
                    d.state = ST_READ_NEXT;
                    d.addr  = q.ptr;
                    d.sent  = 1'b0;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, sent: 1'b0, addr: '0, ptr: '0, found: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign req_ready     = (q.state == ST_IDLE);
    assign mem_req_valid = reading && !q.sent;
    assign mem_req_addr  = q.addr;
    assign res_valid     = (q.state == ST_DONE);
    assign res_found     = q.found;
    assign res_desc_addr = q.ptr;
endmodule

// File: rtl/ep_desc_locator.sv
module ep_desc_locator #(
    parameter int                   AW       = 32,
    parameter int                   DW       = 32,
    parameter int                   NUM_EP   = 32,
    parameter logic [NUM_EP-1:0]    REALIZED = '1,
    localparam int                  IDX_W    = $clog2(NUM_EP),
    localparam int                  ALIGN_W  = IDX_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_wr_en,
    input  logic [AW-1:0]     base_wr_data,
    input  logic [NUM_EP-1:0] ep_dma_en,
    input  logic              req_valid,
    input  logic [IDX_W-1:0]  req_ep,
    output logic              req_ready,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [AW-1:0]     mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [DW-1:0]     mem_rsp_data,
    output logic              res_valid,
    output logic              res_found,
    output logic [AW-1:0]     res_desc_addr,
    input  logic              advance,
    input  logic              xfer_done
);
    logic [AW-1:0] base;
    logic [AW-1:0] entry_addr;
    logic          ep_ok;

    epdl_base_reg #(.AW(AW), .ALIGN_W(ALIGN_W)) base_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (base_wr_en),
        .wr_data (base_wr_data),
        .base_o  (base)
    );

    epdl_entry_sel #(.AW(AW), .NUM_EP(NUM_EP), .IDX_W(IDX_W), .REALIZED(REALIZED)) sel_i (
        .base_i       (base),
        .ep_i         (req_ep),
        .en_mask_i    (ep_dma_en),
        .entry_addr_o (entry_addr),
        .ep_ok_o      (ep_ok)
    );

    epdl_ctrl #(.AW(AW), .DW(DW)) ctrl_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .ep_ok         (ep_ok),
        .entry_addr    (entry_addr),
        .req_ready     (req_ready),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .res_valid     (res_valid),
        .res_found     (res_found),
        .res_desc_addr (res_desc_addr),
        .advance       (advance),
        .xfer_done     (xfer_done)
    );
endmodule

// File: rtl/epdl_checker.sv
module epdl_checker #(
    parameter int AW     = 32,
    parameter int NUM_EP = 32,
    parameter int IDX_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_EP-1:0] ep_dma_en,
    input logic              req_valid,
    input logic [IDX_W-1:0]  req_ep,
    input logic              req_ready,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [AW-1:0]     mem_req_addr,
    input logic              mem_rsp_valid,
    input logic              res_valid,
    input logic              res_found,
    input logic [AW-1:0]     res_desc_addr,
    input logic              advance,
    input logic              xfer_done
);
    logic pending_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= 1'b0;
        end else if (mem_req_valid && mem_req_ready) begin
            pending_q <= 1'b1;
        end else if (mem_rsp_valid) begin
            pending_q <= 1'b0;
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R7

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        pending_q |-> !mem_req_valid); // R7

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid || res_valid) |-> !req_ready); // R3

    AST_ENTRY_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && ep_dma_en[req_ep] |=>
            !mem_req_valid || (mem_req_addr[IDX_W+1:0] == {$past(req_ep), 2'b00})); // R2

    AST_DISABLED_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !ep_dma_en[req_ep] |=> res_valid && !res_found && !mem_req_valid); // R4

    AST_FOUND_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_found |-> res_desc_addr != '0); // R6

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !xfer_done && !advance |=>
            res_valid && $stable(res_found) && $stable(res_desc_addr)); // R9

    AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && xfer_done |=> req_ready); // R9

    AST_ADVANCE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !res_found && advance && !xfer_done |=> res_valid && !mem_req_valid); // R10
endmodule

bind ep_desc_locator epdl_checker #(.AW(AW), .NUM_EP(NUM_EP), .IDX_W(IDX_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .ep_dma_en     (ep_dma_en),
    .req_valid     (req_valid),
    .req_ep        (req_ep),
    .req_ready     (req_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .res_valid     (res_valid),
    .res_found     (res_found),
    .res_desc_addr (res_desc_addr),
    .advance       (advance),
    .xfer_done     (xfer_done)
);

// File: tb/ep_desc_locator_tb_top.sv
module ep_desc_locator_tb_top;
    localparam logic [31:0] REAL = 32'hFFFF_FFFB;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_wr_en = 1'b0;
    logic [31:0] base_wr_data = '0;
    logic [31:0] ep_dma_en = '1;
    logic        req_valid = 1'b0;
    logic [4:0]  req_ep = '0;
    logic        req_ready;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        res_valid;
    logic        res_found;
    logic [31:0] res_desc_addr;
    logic        advance = 1'b0;
    logic        xfer_done = 1'b0;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    ep_desc_locator #(.REALIZED(REAL)) dut_i (
        .clk(clk), .rst_n(rst_n), .base_wr_en(base_wr_en), .base_wr_data(base_wr_data),
        .ep_dma_en(ep_dma_en), .req_valid(req_valid), .req_ep(req_ep), .req_ready(req_ready),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .res_valid(res_valid),
        .res_found(res_found), .res_desc_addr(res_desc_addr), .advance(advance), .xfer_done(xfer_done)
    );

    // memory model: accepts on alternate cycles, answers two cycles later
    logic [31:0] mem [256];
    logic        pend;
    logic [31:0] pend_addr;
    int          lat;
    int          reads;
    logic [31:0] last_addr;
    logic        outstanding;
    int          overlap_err;

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_req_ready <= 1'b0;
            pend <= 1'b0; pend_addr <= '0; lat <= 0;
            mem_rsp_valid <= 1'b0; mem_rsp_data <= '0;
            reads <= 0; last_addr <= '0;
            outstanding <= 1'b0; overlap_err <= 0;
        end else begin
            mem_req_ready <= ~mem_req_ready;
            mem_rsp_valid <= 1'b0;
            if (outstanding && mem_req_valid) overlap_err <= overlap_err + 1;
            if (mem_req_valid && mem_req_ready) begin
                pend <= 1'b1; pend_addr <= mem_req_addr; lat <= 2;
                reads <= reads + 1; last_addr <= mem_req_addr;
                outstanding <= 1'b1;
            end else if (pend) begin
                if (lat == 0) begin
                    mem_rsp_valid <= 1'b1;
                    mem_rsp_data <= mem[pend_addr[9:2]];
                    pend <= 1'b0;
                    outstanding <= 1'b0;
                end else begin
                    lat <= lat - 1;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_base(input logic [31:0] v);
        @(negedge clk); base_wr_en = 1'b1; base_wr_data = v;
        @(negedge clk); base_wr_en = 1'b0;
    endtask

    task automatic issue(input logic [4:0] ep);
        @(negedge clk); req_valid = 1'b1; req_ep = ep;
        @(negedge clk); req_valid = 1'b0;
    endtask

    task automatic wait_res();
        for (int i = 0; i < 40 && !res_valid; i++) @(negedge clk);
    endtask

    task automatic finish_desc();
        @(negedge clk); xfer_done = 1'b1;
        @(negedge clk); xfer_done = 1'b0;
    endtask

    task automatic pulse_adv();
        @(negedge clk); advance = 1'b1;
        @(negedge clk); advance = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(req_ready === 1'b1, "R1 req_ready", 32'(req_ready), 1);
        chk(mem_req_valid === 1'b0, "R1 mem_req_valid", 32'(mem_req_valid), 0);
        chk(res_valid === 1'b0, "R1 res_valid", 32'(res_valid), 0);
        mem[1] = 32'h0;
        issue(5'd1);
        wait_res();
        chk(last_addr == 32'h4, "R1 base zero after reset", last_addr, 32'h4);
        finish_desc();
    endtask

    task automatic t_found();
        int r0;
        write_base(32'h0000_01FF);
        mem[8'h65] = 32'h0000_0300;
        r0 = reads;
        issue(5'd5);
        wait_res();
        chk(last_addr == 32'h194, "R2 table address", last_addr, 32'h194);
        chk(res_valid && res_found, "R6 found", 32'(res_found), 1);
        chk(res_desc_addr == 32'h300, "R6 desc addr", res_desc_addr, 32'h300);
        chk(reads - r0 == 1, "R7 single read", 32'(reads - r0), 1);
        finish_desc();
        chk(req_ready === 1'b1, "R9 idle after done", 32'(req_ready), 1);
    endtask

    task automatic t_high_base();
        write_base(32'hFFFF_FF7F);
        mem[8'hC9] = 32'h0;
        issue(5'd9);
        wait_res();
        chk(last_addr == 32'hFFFF_FF24, "R2 high base", last_addr, 32'hFFFF_FF24);
        finish_desc();
        write_base(32'h0000_0180);
    endtask

    task automatic t_null();
        int r0;
        mem[8'h66] = 32'h0;
        r0 = reads;
        issue(5'd6);
        wait_res();
        repeat (6) @(negedge clk);
        chk(res_valid && !res_found, "R5 null not found", 32'(res_found), 0);
        chk(res_desc_addr == 0, "R5 null addr", res_desc_addr, 0);
        chk(reads - r0 == 1, "R5 no extra read", 32'(reads - r0), 1);
        finish_desc();
    endtask

    task automatic t_disabled();
        int r0;
        mem[8'h67] = 32'h0000_0300;
        ep_dma_en = 32'hFFFF_FF7F;
        r0 = reads;
        issue(5'd7);
        wait_res();
        chk(res_valid && !res_found, "R4 disabled not found", 32'(res_found), 0);
        chk(reads == r0, "R4 disabled no read", 32'(reads - r0), 0);
        finish_desc();
        ep_dma_en = '1;
        mem[8'h62] = 32'h0000_0300;
        issue(5'd2);
        wait_res();
        chk(res_valid && !res_found, "R4 unrealized not found", 32'(res_found), 0);
        chk(reads == r0, "R4 unrealized no read", 32'(reads - r0), 0);
        finish_desc();
    endtask

    task automatic t_busy();
        mem[8'h65] = 32'h0000_0300;
        mem[8'h6A] = 32'h0000_0380;
        issue(5'd5);
        @(negedge clk);
        chk(req_ready === 1'b0, "R3 busy not ready", 32'(req_ready), 0);
        req_valid = 1'b1; req_ep = 5'd10;
        wait_res();
        req_valid = 1'b0;
        chk(last_addr == 32'h194, "R3 busy request ignored addr", last_addr, 32'h194);
        chk(res_desc_addr == 32'h300, "R3 busy request ignored result", res_desc_addr, 32'h300);
        repeat (5) @(negedge clk);
        chk(res_valid && res_desc_addr == 32'h300, "R9 result held", res_desc_addr, 32'h300);
        @(negedge clk); xfer_done = 1'b1; advance = 1'b1;
        @(negedge clk); xfer_done = 1'b0; advance = 1'b0;
        chk(req_ready === 1'b1, "R9 done over advance", 32'(req_ready), 1);
    endtask

    task automatic t_chain();
        int r0;
        mem[8'h68] = 32'h0000_0300;
        mem[8'hC0] = 32'h0000_0340;
        mem[8'hD0] = 32'h0;
        issue(5'd8);
        wait_res();
        pulse_adv();
        wait_res();
        chk(last_addr == 32'h300, "R8 next at offset 0", last_addr, 32'h300);
        chk(res_found && res_desc_addr == 32'h340, "R8 next desc", res_desc_addr, 32'h340);
        pulse_adv();
        wait_res();
        chk(last_addr == 32'h340, "R8 second next read", last_addr, 32'h340);
        chk(res_valid && !res_found, "R8 end of chain", 32'(res_found), 0);
        r0 = reads;
        pulse_adv();
        repeat (6) @(negedge clk);
        chk(reads == r0, "R10 advance ignored no read", 32'(reads - r0), 0);
        chk(res_valid && !res_found, "R10 result kept", 32'(res_valid), 1);
        finish_desc();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_found();
        t_high_base();
        t_null();
        t_disabled();
        t_busy();
        t_chain();
        chk(overlap_err == 0, "R7 one outstanding", 32'(overlap_err), 0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule